// File: doc/BRIEF.md
# Fractional Audio Sample-Rate Tick Generator Bank

This block holds a bank of independent fractional rate generators. Each one picks one of two base sample strobes, at 48 kHz or at 44.1 kHz, or is switched off. It then produces a stream of single-cycle output ticks whose average rate is the base rate times an increment, divided by a modulus. The output stream is made by an error accumulator in the style of a line-drawing algorithm. On every selected base strobe the accumulator gains the increment. Whenever the accumulator reaches the modulus, the modulus is taken away and one tick is issued.

A shared configuration bus carries a source-select word, an increment word and a modulus-control word. A per-generator write strobe latches the bus into one generator. The modulus is not written directly. It is derived from the increment and the modulus-control word. Every write restarts the generator's accumulator from zero. The base strobes are produced elsewhere and arrive as one-cycle pulses in the block's clock domain.

Top module: `frac_tick_bank`

## Requirements
- R1: After a synchronous active-high reset, every tick output is low and every accumulator is zero. Every generator is switched off (select code 2) with an increment of zero.
- R2: The select field is 2 bits wide. Select code 0 makes a generator advance only on `base48_i`. Code 1 makes it advance only on `base441_i`. The strobe that is not selected has no effect on ticks.
- R3: Select codes 2 and 3 switch a generator off. Its tick output stays low on both base strobes, and its accumulator is held at zero.
- R4: The modulus equals 2^16 minus (modulus-control + 1 − increment), with the whole expression taken modulo 2^16. For example, an increment of 2 with a modulus-control of 0xFFFC gives a modulus of 5.
- R5: When the R4 expression evaluates to zero, the generator uses a modulus of 1.
- R6: Each selected base strobe adds the increment to the accumulator. When the sum is at least the modulus, the modulus is subtracted and a tick is issued. The tick is high in the cycle after the strobe and lasts exactly one cycle. When the increment is below the modulus, N strobes after a clear give floor(N·increment/modulus) ticks.
- R7: When the increment is at least the modulus, the generator issues a tick on every selected strobe and keeps its accumulator at zero.
- R8: An increment of zero never produces a tick.
- R9: A write strobe latches the select, increment and modulus-control words into that generator and clears its accumulator. The new settings apply from the next cycle.
- R10: Each generator has its own write strobe. A write to one generator does not change the settings, accumulator or ticks of any other generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| base48_i | input | 1 | One-cycle strobe at the 48 kHz base rate |
| base441_i | input | 1 | One-cycle strobe at the 44.1 kHz base rate |
| cfg_wr_i | input | NGEN | Per-generator configuration write strobe |
| cfg_sel_i | input | 2 | Source select: 0 = 48 kHz, 1 = 44.1 kHz, 2 or 3 = off |
| cfg_inc_i | input | W | Increment word |
| cfg_modc_i | input | W | Modulus-control word |
| tick_o | output | NGEN | Registered one-cycle output tick per generator |

## Verification
The bench counts ticks after each strobe and checks the exact strobe that yields the first tick, so an accumulator that compares with the wrong relation or subtracts late is caught as a tick one strobe too early or too late. A modulus-control value equal to the increment minus one forces the zero-modulus case: a design that used 2^16 in that case would stay silent where a tick is expected on every strobe. Saturation with increment equal to the modulus and a rewrite in the middle of a count both make errors visible as changed tick totals. A bad decode of the select field shows up as ticks taken from the wrong base strobe or ticks from a generator that is switched off. A partial write to a single generator checks that the other generators keep their accumulator phase.

// File: rtl/frg_pkg.sv
package frg_pkg;
  // Source-select encoding; codes 2 and 3 both park the generator.
  typedef enum logic [1:0] {
    SRC_48K   = 2'd0,
    SRC_44K1  = 2'd1,
    SRC_OFF   = 2'd2,
    SRC_OFF_X = 2'd3
  } src_sel_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/frg_modulus.sv
// Derives the effective modulus from the programmed words (R4, R5).
module frg_modulus #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] modc_i,
  output logic [W:0]   mod_o
);
  logic [W-1:0] span;
  logic [W-1:0] raw;

  always_comb begin
    span = modc_i + W'(1) - inc_i;  // wraps modulo 2^W
    raw  = '0 - span;                // 2^W - span, modulo 2^W
    // R5: a zero result means a modulus of one
    mod_o = (raw == '0) ? (W+1)'(1) : {1'b0, raw};
  end
endmodule

// File: rtl/frg_src_mux.sv
// Picks the base strobe named by the select code (R2, R3).
module frg_src_mux
  import frg_pkg::*;
(
  input  src_sel_e sel_i,
  input  logic     base48_i,
  input  logic     base441_i,
  output logic     step_o,
  output logic     en_o
);
  always_comb begin
    unique case (sel_i)
      SRC_48K:  begin step_o = base48_i;  en_o = 1'b1; end
      SRC_44K1: begin step_o = base441_i; en_o = 1'b1; end
      default:  begin step_o = 1'b0;      en_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/frg_accum.sv
// Error accumulator with registered tick (R6, R7, R8, R9).
module frg_accum #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] inc_i,
  input  logic [W:0]   mod_i,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;
  logic         sat;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, inc_i};
    sat = ({1'b0, inc_i} >= mod_i);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i || !en_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (step_i) begin
      if (sat) begin
        acc_q  <= '0;
        tick_o <= 1'b1;
      end else if (sum >= mod_i) begin
        acc_q  <= W'(sum - mod_i);
        tick_o <= 1'b1;
      end else begin
        acc_q  <= W'(sum);
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end

  // R6: a tick only ever follows an accepted base strobe
  a_r6_tick_after_step: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(step_i && en_i && !clr_i));
  // R6: the residue stays below the modulus in force
  a_r6_acc_below_mod: assert property (@(posedge clk) disable iff (rst)
    {1'b0, acc_q} < mod_i);
  // R7: a saturating increment ticks on every accepted strobe
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (step_i && en_i && !clr_i && sat) |=> (tick_o && acc_q == '0));
  // R8: zero increment never ticks
  a_r8_zero_inc: assert property (@(posedge clk) disable iff (rst)
    (inc_i == '0) |=> !tick_o);
  // R3: a parked generator keeps residue and tick at zero
  a_r3_off_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (acc_q == '0 && !tick_o));
  // R9: a configuration write restarts from zero
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (acc_q == '0 && !tick_o));
endmodule

// File: rtl/frg_channel.sv
// One generator: configuration latch, source mux, modulus and accumulator.
module frg_channel
  import frg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [W-1:0]     inc_i,
  input  logic [W-1:0]     modc_i,
  input  logic             base48_i,
  input  logic             base441_i,
  output logic             tick_o
);
  src_sel_e     sel_q;
  logic [W-1:0] inc_q;
  logic [W-1:0] modc_q;
  logic [W:0]   mod_w;
  logic         step_w;
  logic         en_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SRC_OFF;
      inc_q  <= '0;
      modc_q <= '0;
    end else if (wr_i) begin
      sel_q  <= src_sel_e'(sel_i);
      inc_q  <= inc_i;
      modc_q <= modc_i;
    end
  end

  frg_modulus #(.W(W)) u_mod (
    .inc_i  (inc_q),
    .modc_i (modc_q),
    .mod_o  (mod_w)
  );

  frg_src_mux u_mux (
    .sel_i     (sel_q),
    .base48_i  (base48_i),
    .base441_i (base441_i),
    .step_o    (step_w),
    .en_o      (en_w)
  );

  frg_accum #(.W(W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (wr_i),
    .en_i   (en_w),
    .step_i (step_w),
    .inc_i  (inc_q),
    .mod_i  (mod_w),
    .tick_o (tick_o)
  );

  // R5: the modulus fed to the accumulator is never zero
  a_r5_mod_nonzero: assert property (@(posedge clk) disable iff (rst)
    mod_w != '0);
  // R2: a strobe from the unselected base never yields a tick
  a_r2_src_48_only: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SRC_48K && !base48_i) |=> !tick_o);
  a_r2_src_441_only: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SRC_44K1 && !base441_i) |=> !tick_o);
endmodule

// File: rtl/frac_tick_bank.sv
// Bank of independent fractional tick generators sharing a config bus.
module frac_tick_bank
  import frg_pkg::*;
#(
  parameter int unsigned NGEN = 3,
  parameter int unsigned W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base48_i,
  input  logic             base441_i,
  input  logic [NGEN-1:0]  cfg_wr_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [W-1:0]     cfg_inc_i,
  input  logic [W-1:0]     cfg_modc_i,
  output logic [NGEN-1:0]  tick_o
);
  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    frg_channel #(.W(W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr_i      (cfg_wr_i[g]),
      .sel_i     (cfg_sel_i),
      .inc_i     (cfg_inc_i),
      .modc_i    (cfg_modc_i),
      .base48_i  (base48_i),
      .base441_i (base441_i),
      .tick_o    (tick_o[g])
    );
  end

  // R1: all ticks low in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (tick_o == '0));
endmodule

// File: tb/test_frac_tick_bank.sv
module test_frac_tick_bank;
  localparam int NGEN = 3;
  localparam int W    = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            b48 = 1'b0;
  logic            b44 = 1'b0;
  logic [NGEN-1:0] wr  = '0;
  logic [1:0]      sel = '0;
  logic [W-1:0]    inc = '0;
  logic [W-1:0]    modc = '0;
  logic [NGEN-1:0] tick;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  int cnt [NGEN];
  int base [NGEN];

  always #5 clk = ~clk;

  frac_tick_bank #(.NGEN(NGEN), .W(W)) i_frac_tick_bank (
    .clk(clk), .rst(rst), .base48_i(b48), .base441_i(b44),
    .cfg_wr_i(wr), .cfg_sel_i(sel), .cfg_inc_i(inc), .cfg_modc_i(modc),
    .tick_o(tick)
  );

  initial for (int g = 0; g < NGEN; g++) cnt[g] = 0;

  always @(negedge clk)
    if (!rst) for (int g = 0; g < NGEN; g++) cnt[g] += int'(tick[g]);

  task automatic mark();
    for (int g = 0; g < NGEN; g++) base[g] = cnt[g];
  endtask

  task automatic expect_cnt(input int g, input int exp, input string req);
    int got;
    got = cnt[g] - base[g];
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s gen%0d ticks actual=%0d expected=%0d", req, g, got, exp);
    end
  endtask

  task automatic cfg(input logic [NGEN-1:0] m, input logic [1:0] s,
                     input logic [W-1:0] i, input logic [W-1:0] mc);
    @(negedge clk);
    wr = m; sel = s; inc = i; modc = mc;
    @(negedge clk);
    wr = '0;
    @(negedge clk);
  endtask

  // which: 0 = 48 kHz strobe, 1 = 44.1 kHz strobe
  task automatic pulse(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (which == 0) b48 = 1'b1; else b44 = 1'b1;
      @(negedge clk);
      b48 = 1'b0; b44 = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    mark();
    repeat (3) @(negedge clk);
    tests++;
    if (tick !== '0) begin
      fails++;
      $display("FAIL R1 tick actual=%b expected=000", tick);
    end
    pulse(0, 4); pulse(1, 4);
    expect_cnt(0, 0, "R1"); expect_cnt(1, 0, "R1"); expect_cnt(2, 0, "R1");
  endtask

  task automatic t_base48();
    cfg(3'b001, 2'd0, 16'd1, 16'hFFFC);   // modulus 4
    mark(); pulse(0, 3); expect_cnt(0, 0, "R6");
    pulse(0, 1); expect_cnt(0, 1, "R6");
    pulse(0, 16); expect_cnt(0, 5, "R6");
    expect_cnt(1, 0, "R10"); expect_cnt(2, 0, "R10");
  endtask

  task automatic t_base441();
    cfg(3'b010, 2'd1, 16'd3, 16'hFFFB);   // modulus 7
    mark(); pulse(0, 10); expect_cnt(1, 0, "R2");
    pulse(1, 14); expect_cnt(1, 6, "R2");
  endtask

  task automatic t_off();
    cfg(3'b100, 2'd2, 16'd1, 16'hFFFC);
    mark(); pulse(0, 8); pulse(1, 8); expect_cnt(2, 0, "R3");
    cfg(3'b100, 2'd3, 16'd1, 16'hFFFC);
    mark(); pulse(0, 8); pulse(1, 8); expect_cnt(2, 0, "R3");
  endtask

  task automatic t_formula();
    cfg(3'b001, 2'd0, 16'd2, 16'hFFFC);   // modulus 5
    mark(); pulse(0, 2); expect_cnt(0, 0, "R4");
    pulse(0, 1); expect_cnt(0, 1, "R4");
    pulse(0, 22); expect_cnt(0, 10, "R4");
  endtask

  task automatic t_zero_mod();
    cfg(3'b001, 2'd0, 16'd5, 16'd4);      // raw modulus 0 -> 1
    mark(); pulse(0, 10); expect_cnt(0, 10, "R5");
  endtask

  task automatic t_saturate();
    cfg(3'b010, 2'd1, 16'hFFFF, 16'hFFFF); // modulus 0xFFFF == inc
    mark(); pulse(1, 6); expect_cnt(1, 6, "R7");
  endtask

  task automatic t_zero_inc();
    cfg(3'b100, 2'd0, 16'd0, 16'hFFFC);
    mark(); pulse(0, 12); expect_cnt(2, 0, "R8");
  endtask

  task automatic t_rewrite();
    cfg(3'b001, 2'd0, 16'd1, 16'hFFFC);
    mark(); pulse(0, 3);
    cfg(3'b001, 2'd0, 16'd1, 16'hFFFC);
    pulse(0, 3); expect_cnt(0, 0, "R9");
    pulse(0, 1); expect_cnt(0, 1, "R9");
  endtask

  task automatic t_indep();
    cfg(3'b001, 2'd0, 16'd1, 16'hFFFC);   // mod 4
    cfg(3'b010, 2'd0, 16'd2, 16'hFFFC);   // mod 5
    cfg(3'b100, 2'd1, 16'd1, 16'hFFFE);   // mod 2
    mark(); pulse(0, 10); pulse(1, 6);
    expect_cnt(0, 2, "R10"); expect_cnt(1, 4, "R10"); expect_cnt(2, 3, "R10");
    cfg(3'b010, 2'd2, 16'd0, 16'd0);
    mark(); pulse(0, 2);
    expect_cnt(0, 1, "R10"); expect_cnt(1, 0, "R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_base48();
    t_base441();
    t_off();
    t_formula();
    t_zero_mod();
    t_saturate();
    t_zero_inc();
    t_rewrite();
    t_indep();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule